// File: doc/BRIEF.md
# Multicycle Processor Sequencing Controller

This block sequences a 32-bit multicycle processor that reuses one ALU and one memory port for every step of an instruction. It watches the opcode and function fields of the instruction register and the ALU zero flag. It walks each instruction through its own chain of steps. In every step it drives the write enables for the program counter, the instruction register, the branch-target register, the register file and memory, plus the memory read strobe, the datapath multiplexer selects and the ALU operation code. The datapath, memory and register file sit outside the block.

Every control output except the program-counter write enable is a flip-flop output. Each value is computed one cycle early from the next state and then registered. During a conditional branch, the program-counter write enable is the only output that combines registered state with the live zero flag.

Every field that a step does not name reads 0. Select encodings are:
- addr_sel: 0 for PC, 1 for ALUout.
- alu_a_sel: 0 for PC, 1 for the latched Rs.
- alu_b_sel: 0 for the latched Rt, 1 for constant 4, 2 for SX(imm), 3 for SX(imm)<<2.
- pc_src: 0 for the ALU result, 1 for BPC, 2 for the jump target.
- rf_dst: 0 for Rd, 1 for Rt, 2 for register 31.
- rf_data_sel: 0 for ALUout, 1 for the memory data register.

ALU codes are ADD=0, SUB=1, AND=2, OR=3, SLT=4.

Top module: `mcc_top`

## Requirements
- R1: While rst_n is low at a clock edge, every enable and strobe is 0 in the following cycle. The first edge with rst_n high starts a fetch step.
- R2: A fetch step asserts mem_rd, ir_we and pc_we, with addr_sel=0, alu_a_sel=0, alu_b_sel=1, alu_op=ADD and pc_src=0.
- R3: Every fetch step is followed by a decode step: bpc_we=1, alu_a_sel=0, alu_b_sel=3, alu_op=ADD.
- R4: Opcode 0 runs an execute step (alu_a_sel=1, alu_b_sel=0) and then a write-back step (rf_we, rf_dst=0, rf_data_sel=0). The funct field sets the ALU code: 32 gives ADD, 34 SUB, 36 AND, 37 OR, 42 SLT, and any other value ADD.
- R5: Opcodes 8 (ADD), 12 (AND), 13 (OR) and 10 (SLT) run an execute step (alu_a_sel=1, alu_b_sel=2, ALU code from the opcode) and then a write-back step to Rt (rf_we, rf_dst=1).
- R6: Opcode 35 runs an address step (alu_a_sel=1, alu_b_sel=2, ADD), then a read step (mem_rd, addr_sel=1), then a write-back step (rf_we, rf_dst=1, rf_data_sel=1).
- R7: Opcode 43 runs the same address step and then a store step (mem_we, addr_sel=1), and then returns to fetch.
- R8: Opcodes 4 and 5 run one compare step (alu_a_sel=1, alu_b_sel=0, SUB, pc_src=1). In that step pc_we equals zero for opcode 4 and the inverse of zero for opcode 5.
- R9: Opcode 2 runs one step with pc_we=1 and pc_src=2, while the ALU is held at PC+4 (alu_a_sel=0, alu_b_sel=1, ADD).
- R10: Opcode 3 runs three steps. First, PC takes PC+4 (pc_we, pc_src=0, ALU PC+4). Second, the ALU computes PC-4 (alu_b_sel=1, SUB). Third, in one step, rf_we with rf_dst=2 and rf_data_sel=0 writes register 31, and pc_we with pc_src=2 loads the jump target.
- R11: Any other opcode goes from decode straight back to fetch, with no enable or strobe asserted in between.
- R12: Within a step, changing opcode or funct changes no output. The zero flag affects only pc_we, and only in the compare step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| zero | input | 1 | ALU result-is-zero flag |
| pc_we | output | 1 | Program counter write |
| ir_we | output | 1 | Instruction register write |
| bpc_we | output | 1 | Branch-target register write |
| rf_we | output | 1 | Register file write |
| mem_we | output | 1 | Memory write |
| mem_rd | output | 1 | Memory read strobe |
| addr_sel | output | 1 | Memory address source |
| alu_a_sel | output | 1 | ALU first operand source |
| alu_b_sel | output | 2 | ALU second operand source |
| pc_src | output | 2 | Program counter source |
| rf_dst | output | 2 | Register write address source |
| rf_data_sel | output | 1 | Register write data source |
| alu_op | output | 4 | ALU operation code |

## Verification
The link-and-jump write-back step does two things in the same cycle: it writes register 31 and loads the jump target into PC. The sweep reaches this step through opcode 3 and compares the complete control word there. The check passes only if rf_we with rf_dst=2 and pc_we with pc_src=2 appear together, and neither appears alone. The compare step is a second case of two things meeting in one cycle: the registered BPC select and the live zero flag. Every opcode is run with zero both low and high, so a branch whose write condition is inverted, or a zero flag that leaks into another step, shows up as a word mismatch.

// File: rtl/mcc_pkg.sv
// Shared types and encodings for the multicycle sequencing controller.
// Assumes 6-bit opcode and funct fields; all select codes are fixed here.
package mcc_pkg;

    localparam int ALU_OP_W = 4;

    localparam logic [ALU_OP_W-1:0] ALU_ADD = 4'd0;
    localparam logic [ALU_OP_W-1:0] ALU_SUB = 4'd1;
    localparam logic [ALU_OP_W-1:0] ALU_AND = 4'd2;
    localparam logic [ALU_OP_W-1:0] ALU_OR  = 4'd3;
    localparam logic [ALU_OP_W-1:0] ALU_SLT = 4'd4;

    localparam int OPC_RTYPE = 0;
    localparam int OPC_J     = 2;
    localparam int OPC_JAL   = 3;
    localparam int OPC_BEQ   = 4;
    localparam int OPC_BNE   = 5;
    localparam int OPC_ADDI  = 8;
    localparam int OPC_SLTI  = 10;
    localparam int OPC_ANDI  = 12;
    localparam int OPC_ORI   = 13;
    localparam int OPC_LW    = 35;
    localparam int OPC_SW    = 43;

    localparam int FN_ADD = 32;
    localparam int FN_SUB = 34;
    localparam int FN_AND = 36;
    localparam int FN_OR  = 37;
    localparam int FN_SLT = 42;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH, S_DECODE, S_EXR, S_EXI, S_WBRD, S_WBRT, S_ADDR,
        S_MRD, S_WBMEM, S_MWR, S_BR, S_JMP, S_JAL1, S_JAL2, S_JALWB
    } state_t;

    typedef enum logic [2:0] {
        CL_R, CL_I, CL_LW, CL_SW, CL_BR, CL_J, CL_JAL, CL_BAD
    } iclass_t;

    typedef struct packed {
        logic                pc_we;
        logic                ir_we;
        logic                bpc_we;
        logic                rf_we;
        logic                mem_we;
        logic                mem_rd;
        logic                addr_sel;
        logic                alu_a_sel;
        logic [1:0]          alu_b_sel;
        logic [1:0]          pc_src;
        logic [1:0]          rf_dst;
        logic                rf_data_sel;
        logic [ALU_OP_W-1:0] alu_op;
        logic                br_en;
        logic                br_ne;
    } ctl_t;

endpackage

// File: rtl/mcc_classify.sv
// Instruction classifier: maps opcode to an instruction class and derives
// the ALU codes for register and immediate arithmetic.
// Assumes the fields are stable from the end of fetch until the next fetch.
module mcc_classify
    import mcc_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int FN_W = 6
) (
    input  logic [OP_W-1:0]     opcode,
    input  logic [FN_W-1:0]     funct,
    output iclass_t             cls,
    output logic [ALU_OP_W-1:0] alu_r,
    output logic [ALU_OP_W-1:0] alu_i,
    output logic                is_bne
);

    // Opcode to instruction class
    always_comb begin
        case (opcode)
            OP_W'(OPC_RTYPE):                   cls = CL_R;
            OP_W'(OPC_ADDI), OP_W'(OPC_SLTI),
            OP_W'(OPC_ANDI), OP_W'(OPC_ORI):    cls = CL_I;
            OP_W'(OPC_LW):                      cls = CL_LW;
            OP_W'(OPC_SW):                      cls = CL_SW;
            OP_W'(OPC_BEQ), OP_W'(OPC_BNE):     cls = CL_BR;
            OP_W'(OPC_J):                       cls = CL_J;
            OP_W'(OPC_JAL):                     cls = CL_JAL;
            default:                            cls = CL_BAD;
        endcase
    end

    // Function field to ALU code for register arithmetic
    always_comb begin
        case (funct)
            FN_W'(FN_SUB): alu_r = ALU_SUB;
            FN_W'(FN_AND): alu_r = ALU_AND;
            FN_W'(FN_OR):  alu_r = ALU_OR;
            FN_W'(FN_SLT): alu_r = ALU_SLT;
            default:       alu_r = ALU_ADD;
        endcase
    end

    // Opcode to ALU code for immediate arithmetic
    always_comb begin
        case (opcode)
            OP_W'(OPC_ANDI): alu_i = ALU_AND;
            OP_W'(OPC_ORI):  alu_i = ALU_OR;
            OP_W'(OPC_SLTI): alu_i = ALU_SLT;
            default:         alu_i = ALU_ADD;
        endcase
    end

    assign is_bne = (opcode == OP_W'(OPC_BNE));

endmodule

// File: rtl/mcc_seq.sv
// Step sequencer: holds the current step and computes the next one from
// the instruction class. Reset parks it in an idle step that leads to fetch.
module mcc_seq
    import mcc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  iclass_t cls,
    output state_t  state_q,
    output state_t  state_nx
);

    // Next-step selection
    always_comb begin
        case (state_q)
            S_IDLE:   state_nx = S_FETCH;
            S_FETCH:  state_nx = S_DECODE;
            S_DECODE: begin
                case (cls)
                    CL_R:          state_nx = S_EXR;
                    CL_I:          state_nx = S_EXI;
                    CL_LW, CL_SW:  state_nx = S_ADDR;
                    CL_BR:         state_nx = S_BR;
                    CL_J:          state_nx = S_JMP;
                    CL_JAL:        state_nx = S_JAL1;
                    default:       state_nx = S_FETCH;
                endcase
            end
            S_EXR:    state_nx = S_WBRD;
            S_EXI:    state_nx = S_WBRT;
            S_ADDR:   state_nx = (cls == CL_LW) ? S_MRD : S_MWR;
            S_MRD:    state_nx = S_WBMEM;
            S_JAL1:   state_nx = S_JAL2;
            S_JAL2:   state_nx = S_JALWB;
            default:  state_nx = S_FETCH;
        endcase
    end

    // Step register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

endmodule

// File: rtl/mcc_ctlgen.sv
// Control word generator: pure function from a step to its control word.
// Fed with the next step so the top can register the result.
module mcc_ctlgen
    import mcc_pkg::*;
(
    input  state_t              st,
    input  logic [ALU_OP_W-1:0] alu_r,
    input  logic [ALU_OP_W-1:0] alu_i,
    input  logic                is_bne,
    output ctl_t                ctl
);

    // Per-step control values, every unnamed field held at 0
    always_comb begin
        ctl = '0;
        case (st)
            S_FETCH: begin
                ctl.mem_rd = 1'b1; ctl.ir_we = 1'b1; ctl.pc_we = 1'b1;
                ctl.alu_b_sel = 2'd1;
            end
            S_DECODE: begin
                ctl.bpc_we = 1'b1; ctl.alu_b_sel = 2'd3;
            end
            S_EXR: begin
                ctl.alu_a_sel = 1'b1; ctl.alu_op = alu_r;
            end
            S_EXI: begin
                ctl.alu_a_sel = 1'b1; ctl.alu_b_sel = 2'd2; ctl.alu_op = alu_i;
            end
            S_WBRD:  ctl.rf_we = 1'b1;
            S_WBRT: begin
                ctl.rf_we = 1'b1; ctl.rf_dst = 2'd1;
            end
            S_ADDR: begin
                ctl.alu_a_sel = 1'b1; ctl.alu_b_sel = 2'd2;
            end
            S_MRD: begin
                ctl.mem_rd = 1'b1; ctl.addr_sel = 1'b1;
            end
            S_WBMEM: begin
                ctl.rf_we = 1'b1; ctl.rf_dst = 2'd1; ctl.rf_data_sel = 1'b1;
            end
            S_MWR: begin
                ctl.mem_we = 1'b1; ctl.addr_sel = 1'b1;
            end
            S_BR: begin
                ctl.alu_a_sel = 1'b1; ctl.pc_src = 2'd1; ctl.alu_op = ALU_SUB;
                ctl.br_en = 1'b1; ctl.br_ne = is_bne;
            end
            S_JMP: begin
                ctl.pc_we = 1'b1; ctl.pc_src = 2'd2; ctl.alu_b_sel = 2'd1;
            end
            S_JAL1: begin
                ctl.pc_we = 1'b1; ctl.alu_b_sel = 2'd1;
            end
            S_JAL2: begin
                ctl.alu_b_sel = 2'd1; ctl.alu_op = ALU_SUB;
            end
            S_JALWB: begin
                ctl.rf_we = 1'b1; ctl.rf_dst = 2'd2;
                ctl.pc_we = 1'b1; ctl.pc_src = 2'd2;
            end
            default: ctl = '0;
        endcase
    end

endmodule

// File: rtl/mcc_top.sv
// Multicycle sequencing controller top. Classifies the instruction, steps
// the sequencer, and registers the next step's control word so every select
// leaves a flip-flop directly. Only pc_we mixes in the live zero flag,
// during the compare step. Assumes opcode/funct held from fetch onward.
module mcc_top
    import mcc_pkg::*;
#(
    parameter int OP_W = 6,
    parameter int FN_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     opcode,
    input  logic [FN_W-1:0]     funct,
    input  logic                zero,
    output logic                pc_we,
    output logic                ir_we,
    output logic                bpc_we,
    output logic                rf_we,
    output logic                mem_we,
    output logic                mem_rd,
    output logic                addr_sel,
    output logic                alu_a_sel,
    output logic [1:0]          alu_b_sel,
    output logic [1:0]          pc_src,
    output logic [1:0]          rf_dst,
    output logic                rf_data_sel,
    output logic [ALU_OP_W-1:0] alu_op
);

    iclass_t             cls;
    logic [ALU_OP_W-1:0] alu_r;
    logic [ALU_OP_W-1:0] alu_i;
    logic                is_bne;
    state_t              state_q;
    state_t              state_nx;
    ctl_t                ctl_nx;
    ctl_t                ctl_q;

    mcc_classify #(.OP_W(OP_W), .FN_W(FN_W)) u_cls (
        .opcode (opcode),
        .funct  (funct),
        .cls    (cls),
        .alu_r  (alu_r),
        .alu_i  (alu_i),
        .is_bne (is_bne)
    );

    mcc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cls      (cls),
        .state_q  (state_q),
        .state_nx (state_nx)
    );

    mcc_ctlgen u_gen (
        .st     (state_nx),
        .alu_r  (alu_r),
        .alu_i  (alu_i),
        .is_bne (is_bne),
        .ctl    (ctl_nx)
    );

    // Control word register: outputs come straight from these flops
    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_nx;
    end

    assign pc_we       = ctl_q.pc_we | (ctl_q.br_en & (zero ^ ctl_q.br_ne));
    assign ir_we       = ctl_q.ir_we;
    assign bpc_we      = ctl_q.bpc_we;
    assign rf_we       = ctl_q.rf_we;
    assign mem_we      = ctl_q.mem_we;
    assign mem_rd      = ctl_q.mem_rd;
    assign addr_sel    = ctl_q.addr_sel;
    assign alu_a_sel   = ctl_q.alu_a_sel;
    assign alu_b_sel   = ctl_q.alu_b_sel;
    assign pc_src      = ctl_q.pc_src;
    assign rf_dst      = ctl_q.rf_dst;
    assign rf_data_sel = ctl_q.rf_data_sel;
    assign alu_op      = ctl_q.alu_op;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !(pc_we | ir_we | bpc_we | rf_we | mem_we | mem_rd)); // R1

    AST_DECODE_FOLLOWS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (bpc_we && alu_b_sel == 2'd3)); // R3

    AST_LOAD_WRITEBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && addr_sel) |=> (rf_we && rf_data_sel && rf_dst == 2'd1)); // R6

    AST_STORE_THEN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (ir_we && mem_rd)); // R7

    AST_BRANCH_IS_COMPARE: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src == 2'd1) |-> (alu_op == ALU_SUB && alu_a_sel)); // R8

    AST_LINK_WITH_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_dst == 2'd2) |-> (pc_we && pc_src == 2'd2)); // R10

    AST_LINK_PRECEDED: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we && rf_dst == 2'd2) |-> ($past(alu_op) == ALU_SUB && !$past(pc_we))); // R10

    AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && rf_we)); // R12

endmodule

// File: tb/sim_mcc_top.sv
module sim_mcc_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = '0;
    logic [5:0] funct = '0;
    logic       zero = 1'b0;
    logic       pc_we, ir_we, bpc_we, rf_we, mem_we, mem_rd;
    logic       addr_sel, alu_a_sel, rf_data_sel;
    logic [1:0] alu_b_sel, pc_src, rf_dst;
    logic [3:0] alu_op;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mcc_top u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .zero(zero),
        .pc_we(pc_we), .ir_we(ir_we), .bpc_we(bpc_we), .rf_we(rf_we),
        .mem_we(mem_we), .mem_rd(mem_rd), .addr_sel(addr_sel),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .pc_src(pc_src),
        .rf_dst(rf_dst), .rf_data_sel(rf_data_sel), .alu_op(alu_op)
    );

    localparam int F = 0, D = 1, XR = 2, XI = 3, WD = 4, WT = 5, AD = 6, MR = 7;
    localparam int WM = 8, MW = 9, BR = 10, JJ = 11, J1 = 12, J2 = 13, JW = 14;

    function automatic logic [18:0] mk(input bit pcw, irw, bpw, rfw, mw, mr, as,
                                       aa, input int ab, ps, rd, input bit rds,
                                       input int op);
        return {pcw, irw, bpw, rfw, mw, mr, as, aa, 2'(ab), 2'(ps), 2'(rd),
                rds, 4'(op)};
    endfunction

    function automatic int ralu(input int fn);
        case (fn)
            34: return 1; 36: return 2; 37: return 3; 42: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int ialu(input int op);
        case (op)
            12: return 2; 13: return 3; 10: return 4;
            default: return 0;
        endcase
    endfunction

    function automatic logic [18:0] expw(input int st, op, fn, input bit z);
        case (st)
            F:  return mk(1,1,0,0,0,1,0,0,1,0,0,0,0);
            D:  return mk(0,0,1,0,0,0,0,0,3,0,0,0,0);
            XR: return mk(0,0,0,0,0,0,0,1,0,0,0,0,ralu(fn));
            XI: return mk(0,0,0,0,0,0,0,1,2,0,0,0,ialu(op));
            WD: return mk(0,0,0,1,0,0,0,0,0,0,0,0,0);
            WT: return mk(0,0,0,1,0,0,0,0,0,0,1,0,0);
            AD: return mk(0,0,0,0,0,0,0,1,2,0,0,0,0);
            MR: return mk(0,0,0,0,0,1,1,0,0,0,0,0,0);
            WM: return mk(0,0,0,1,0,0,0,0,0,0,1,1,0);
            MW: return mk(0,0,0,0,1,0,1,0,0,0,0,0,0);
            BR: return mk(z ^ (op == 5),0,0,0,0,0,0,1,0,1,0,0,1);
            JJ: return mk(1,0,0,0,0,0,0,0,1,2,0,0,0);
            J1: return mk(1,0,0,0,0,0,0,0,1,0,0,0,0);
            J2: return mk(0,0,0,0,0,0,0,0,1,0,0,0,1);
            JW: return mk(1,0,0,1,0,0,0,0,0,2,2,0,0);
            default: return '0;
        endcase
    endfunction

    function automatic logic [18:0] actual();
        return {pc_we, ir_we, bpc_we, rf_we, mem_we, mem_rd, addr_sel, alu_a_sel,
                alu_b_sel, pc_src, rf_dst, rf_data_sel, alu_op};
    endfunction

    task automatic check(input logic [18:0] exp, input string req, input int op,
                         input int st);
        total++;
        if (actual() !== exp) begin
            bad++;
            $display("FAIL %s op=%0d step=%0d actual=%b expected=%b",
                     req, op, st, actual(), exp);
        end
    endtask

    function automatic string req_of(input int st, op);
        case (st)
            F: return "R2"; D: return "R3";
            XR, WD: return "R4"; XI, WT: return "R5";
            MR, WM: return "R6"; MW: return "R7";
            AD: return (op == 35) ? "R6" : "R7";
            BR: return "R8"; JJ: return "R9";
            default: return "R10";
        endcase
    endfunction

    // One instruction from its fetch step, output sampled at the negedge
    task automatic run_instr(input int op, fn, input bit z);
        int steps[$];
        case (op)
            0: steps = '{XR, WD};
            8, 10, 12, 13: steps = '{XI, WT};
            35: steps = '{AD, MR, WM};
            43: steps = '{AD, MW};
            4, 5: steps = '{BR};
            2: steps = '{JJ};
            3: steps = '{J1, J2, JW};
            default: steps = {};
        endcase
        check(expw(F, op, fn, z), "R2", op, F);
        opcode = 6'(op); funct = 6'(fn); zero = z;
        @(posedge clk); @(negedge clk);
        check(expw(D, op, fn, z), "R3", op, D);
        foreach (steps[i]) begin
            @(posedge clk); @(negedge clk);
            check(expw(steps[i], op, fn, z), req_of(steps[i], op), op, steps[i]);
            // R12: disturb the fields inside the step, outputs must not move
            opcode = ~6'(op); funct = ~6'(fn);
            #1;
            check(expw(steps[i], op, fn, z), "R12", op, steps[i]);
            opcode = 6'(op); funct = 6'(fn);
        end
        if (steps.size() == 0) begin
            @(posedge clk); @(negedge clk);
            check(expw(F, op, fn, z), "R11", op, F);
        end else begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check('0, "R1", 0, -1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(expw(F, 0, 0, 0), "R1", 0, F);

        for (int op = 0; op < 64; op++) begin
            run_instr(op, 32, 1'b0);
            run_instr(op, 32, 1'b1);
        end
        for (int fn = 0; fn < 64; fn++) run_instr(0, fn, fn[0]);

        // R1: reset in the middle of a load
        opcode = 6'd35; zero = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check(expw(AD, 35, 0, 0), "R6", 35, AD);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check('0, "R1", 35, -1);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check(expw(F, 35, 0, 0), "R1", 35, F);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule